// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block sits beside a host bridge and decides, for every memory access aimed at the legacy region below 1 MiB, whether the access is served by DRAM or forwarded to the PCI bus. It holds the configuration bytes that govern that choice: seven shadow-attribute bytes covering thirteen regions, and one SMRAM control byte covering the 128 KiB window at 0xA0000. It also reports the installed memory size as a read-only byte.

Firmware programs the bytes through a dword-wide configuration port with per-byte lane enables. The access side presents an address, a read/write flag and a flag that marks accesses made while the processor is in system management mode. One cycle later the block answers RAM, PCI, or NONE. NONE means the address is outside the legacy windows, or no access was presented.

Top module: `lmw_decoder`

## Requirements
- R1: After reset every shadow-attribute byte (offsets 0x59..0x5F) reads 0x00 and the SMRAM control byte (offset 0x72) reads 0x02. The configuration port addresses dword `cfg_addr`, and lane k carries byte offset 4*cfg_addr+k in bits 8k+7..8k.
- R2: A configuration write updates only the implemented writable bytes whose lane enable is set. Offset 0x58, offset 0x57 and unimplemented offsets ignore writes; unimplemented offsets read 0.
- R3: Shadow regions are laid out as follows. Region 0 is 0xF0000..0xFFFFF. Regions 1..12 are 16 KiB segments starting at 0xC0000 and run in ascending address order. Region i takes its attribute from byte 0x59+ceil(i/2). Odd regions use the low nibble of that byte; region 0 and the even regions use the high nibble.
- R4: In a shadow region, a read routes to RAM when attribute bit 0 is set, and a write routes to RAM when attribute bit 1 is set. Otherwise the access routes to PCI. The SMM flag has no effect in these regions.
- R5: An access to 0xA0000..0xBFFFF outside SMM routes to RAM when bit 6 (open) of the SMRAM byte is set, and to PCI otherwise.
- R6: An SMM access to that window routes to RAM when bit 3 (enable) of the SMRAM byte is set. Otherwise it follows R5.
- R7: An access below 0xA0000 or at or above 0x100000 (any of the upper address bits set) yields NONE. Route encoding: NONE=0, RAM=1, PCI=2.
- R8: The route appears on the cycle after `acc_valid`, and is NONE on any cycle that follows a cycle without `acc_valid`.
- R9: Offset 0x57 reads `ram_mib`/8 rounded down, saturated at 255.
- R10: A single configuration write changes all affected bytes on the same edge. The first access presented after that edge sees every new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for dword `cfg_addr` (combinational) |
| ram_mib | input | 16 | Installed memory in MiB |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_smm | input | 1 | Access made in system management mode |
| route | output | 2 | Routing decision, registered |

## Verification
The hardest cases to reach from the ports are the nibble-to-region pairing at segment edges and the interplay of the two SMRAM bits with the SMM flag. Each of these shows up only when neighbouring regions carry deliberately different read and write permissions. The stimulus therefore programs asymmetric attributes: read-only in one nibble and write-only in its partner. It then probes the first and last byte of each chosen segment for both directions. Afterwards it steps the SMRAM byte through open-only, enable-only and cleared, and probes the window from inside and outside SMM at each step.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_RAM  = 2'd1,
        ROUTE_PCI  = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        WIN_OUTSIDE = 2'd0,
        WIN_SMRAM   = 2'd1,
        WIN_SHADOW  = 2'd2
    } win_kind_e;

    localparam int NUM_REGIONS   = 13;
    localparam int NUM_ATTR      = 7;
    localparam int REGION_W      = $clog2(NUM_REGIONS);
    localparam int ATTR_IDX_W    = $clog2(NUM_ATTR);

    localparam logic [7:0] OFF_RAMSIZE = 8'h57;
    localparam logic [7:0] OFF_ATTR0   = 8'h59;
    localparam logic [7:0] OFF_SMRAM   = 8'h72;
    localparam logic [7:0] SMRAM_RESET = 8'h02;
    localparam int SMRAM_OPEN_BIT      = 6;
    localparam int SMRAM_EN_BIT        = 3;

    localparam logic [31:0] SMRAM_LO   = 32'h000A_0000;
    localparam logic [31:0] SMRAM_HI   = 32'h000C_0000;
    localparam logic [31:0] SEG_LO     = 32'h000C_0000;
    localparam logic [31:0] BIOS_LO    = 32'h000F_0000;
    localparam logic [31:0] LEGACY_TOP = 32'h0010_0000;
    localparam int SEG_SHIFT           = 14;

    typedef struct packed {
        win_kind_e             kind;
        logic [REGION_W-1:0]   region;
    } win_t;

    typedef struct packed {
        logic       valid;
        logic       write;
        logic       smm;
        win_t       win;
    } acc_t;

    // ceil(region/2): which attribute byte drives a region
    function automatic logic [ATTR_IDX_W-1:0] attr_index(input logic [REGION_W-1:0] r);
        logic [REGION_W:0] t;
        t = {1'b0, r} + 1'b1;
        return ATTR_IDX_W'(t >> 1);
    endfunction

    // odd regions use the low nibble, region 0 and even regions the high one
    function automatic logic [3:0] pick_nibble(input logic [7:0] b,
                                               input logic [REGION_W-1:0] r);
        return r[0] ? b[3:0] : b[7:4];
    endfunction

    function automatic logic [7:0] size_units(input logic [15:0] mib);
        logic [12:0] u;
        u = mib[15:3];
        return (u > 13'd255) ? 8'hFF : u[7:0];
    endfunction

endpackage

// File: rtl/lmw_cfg_regs.sv
module lmw_cfg_regs
    import lmw_pkg::*;
#(
    parameter int CFG_AW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic [15:0]         ram_mib,
    output logic [8*NUM_ATTR-1:0] attr_flat,
    output logic [7:0]          smram_byte
);
    localparam int OFF_W = CFG_AW + 2;

    logic [7:0] attr_q [NUM_ATTR];
    logic [7:0] smram_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < NUM_ATTR; a++) attr_q[a] <= 8'h00;
            smram_q <= SMRAM_RESET;
        end else if (cfg_we) begin
            for (int k = 0; k < 4; k++) begin
                if (cfg_be[k]) begin
                    for (int a = 0; a < NUM_ATTR; a++) begin
                        if ({cfg_addr, 2'(k)} == OFF_W'(OFF_ATTR0) + OFF_W'(a))
                            attr_q[a] <= cfg_wdata[8*k +: 8];
                    end
                    if ({cfg_addr, 2'(k)} == OFF_W'(OFF_SMRAM))
                        smram_q <= cfg_wdata[8*k +: 8];
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < NUM_ATTR; a++) begin
                if ({cfg_addr, 2'(k)} == OFF_W'(OFF_ATTR0) + OFF_W'(a))
                    cfg_rdata[8*k +: 8] = attr_q[a];
            end
            if ({cfg_addr, 2'(k)} == OFF_W'(OFF_SMRAM))
                cfg_rdata[8*k +: 8] = smram_q;
            if ({cfg_addr, 2'(k)} == OFF_W'(OFF_RAMSIZE))
                cfg_rdata[8*k +: 8] = size_units(ram_mib);
        end
    end

    generate
        for (genvar g = 0; g < NUM_ATTR; g++) begin : g_flat
            assign attr_flat[8*g +: 8] = attr_q[g];
        end
    endgenerate

    assign smram_byte = smram_q;

endmodule

// File: rtl/lmw_region_decode.sv
module lmw_region_decode
    import lmw_pkg::*;
(
    input  logic [31:0] addr,
    output win_t        win
);
    logic [31:0] seg_off;

    always_comb begin
        seg_off    = addr - SEG_LO;
        win.kind   = WIN_OUTSIDE;
        win.region = '0;
        if (addr >= SMRAM_LO && addr < SMRAM_HI) begin
            win.kind = WIN_SMRAM;
        end else if (addr >= SEG_LO && addr < BIOS_LO) begin
            win.kind   = WIN_SHADOW;
            win.region = REGION_W'(seg_off[31:SEG_SHIFT]) + 1'b1;
        end else if (addr >= BIOS_LO && addr < LEGACY_TOP) begin
            win.kind   = WIN_SHADOW;
            win.region = '0;
        end
    end

endmodule

// File: rtl/lmw_route.sv
module lmw_route
    import lmw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  acc_t                  acc,
    input  logic [8*NUM_ATTR-1:0] attr_flat,
    input  logic [7:0]            smram_byte,
    output route_e                route_q
);
    logic [3:0] nib;
    logic [7:0] sel_byte;
    route_e     route_d;

    always_comb begin
        sel_byte = attr_flat[8*attr_index(acc.win.region) +: 8];
        nib      = pick_nibble(sel_byte, acc.win.region);
        route_d  = ROUTE_NONE;
        if (acc.valid) begin
            unique case (acc.win.kind)
                WIN_SHADOW: begin
                    if (acc.write) route_d = nib[1] ? ROUTE_RAM : ROUTE_PCI;
                    else           route_d = nib[0] ? ROUTE_RAM : ROUTE_PCI;
                end
                WIN_SMRAM: begin
                    if (acc.smm && smram_byte[SMRAM_EN_BIT]) route_d = ROUTE_RAM;
                    else if (smram_byte[SMRAM_OPEN_BIT])     route_d = ROUTE_RAM;
                    else                                     route_d = ROUTE_PCI;
                end
                default: route_d = ROUTE_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) route_q <= ROUTE_NONE;
        else     route_q <= route_d;
    end

endmodule

// File: rtl/lmw_decoder.sv
module lmw_decoder
    import lmw_pkg::*;
#(
    parameter int CFG_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [15:0]       ram_mib,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_write,
    input  logic              acc_smm,
    output logic [1:0]        route
);
    logic [8*NUM_ATTR-1:0] attr_flat;
    logic [7:0]            smram_byte;
    win_t                  win;
    acc_t                  acc;
    route_e                route_q;

    lmw_cfg_regs #(.CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ram_mib(ram_mib), .attr_flat(attr_flat), .smram_byte(smram_byte)
    );

    lmw_region_decode u_dec (.addr(acc_addr), .win(win));

    always_comb begin
        acc.valid = acc_valid;
        acc.write = acc_write;
        acc.smm   = acc_smm;
        acc.win   = win;
    end

    lmw_route u_route (
        .clk(clk), .rst(rst), .acc(acc), .attr_flat(attr_flat),
        .smram_byte(smram_byte), .route_q(route_q)
    );

    assign route = route_q;

endmodule

// File: rtl/lmw_decoder_chk.sv
module lmw_decoder_chk
    import lmw_pkg::*;
#(
    parameter int CFG_AW = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [31:0]       cfg_rdata,
    input logic [15:0]       ram_mib,
    input logic              acc_valid,
    input logic [31:0]       acc_addr,
    input logic              acc_smm,
    input logic [7:0]        smram_byte,
    input logic [8*NUM_ATTR-1:0] attr_flat,
    input logic [1:0]        route
);
    AST_ROUTE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        route != 2'b11);                                              // R7

    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> route == 2'd0);                                // R8

    AST_OUTSIDE_NONE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_addr < SMRAM_LO || acc_addr >= LEGACY_TOP))
        |=> route == 2'd0);                                           // R7

    AST_SMM_ENABLE_RAM: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_smm && smram_byte[SMRAM_EN_BIT]
         && acc_addr >= SMRAM_LO && acc_addr < SMRAM_HI)
        |=> route == 2'd1);                                           // R6

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(attr_flat) && $stable(smram_byte)));     // R2

    AST_SIZE_SAT: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == CFG_AW'(OFF_RAMSIZE >> 2) && ram_mib >= 16'd2040)
        |-> cfg_rdata[31:24] == 8'hFF);                               // R9
endmodule

bind lmw_decoder lmw_decoder_chk #(.CFG_AW(CFG_AW)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_rdata(cfg_rdata), .ram_mib(ram_mib), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_smm(acc_smm), .smram_byte(smram_byte),
    .attr_flat(attr_flat), .route(route)
);

// File: tb/lmw_decoder_test.sv
module lmw_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [15:0] ram_mib;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic        acc_write;
    logic        acc_smm;
    logic [1:0]  route;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmw_decoder uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ram_mib(ram_mib), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_smm(acc_smm), .route(route)
    );

    // {addr, write, smm, expected route}; NONE=0 RAM=1 PCI=2
    localparam logic [35:0] VEC [NV] = '{
        {32'h000A_0000, 1'b0, 1'b0, 2'd2},   // R5 closed
        {32'h000B_FFFF, 1'b1, 1'b1, 2'd2},   // R6 enable clear
        {32'h000C_0000, 1'b0, 1'b0, 2'd1},   // R3 R4 region 1 read
        {32'h000C_3FFF, 1'b1, 1'b0, 2'd2},   // R4 region 1 write
        {32'h000C_4000, 1'b0, 1'b0, 2'd2},   // R3 region 2 high nibble
        {32'h000C_7FFF, 1'b1, 1'b0, 2'd1},   // R4 region 2 write
        {32'h000C_8000, 1'b0, 1'b0, 2'd2},   // R4 region 3 cleared
        {32'h000E_8000, 1'b0, 1'b0, 2'd1},   // R3 region 11 low
        {32'h000E_BFFF, 1'b1, 1'b0, 2'd2},   // R4 region 11 write
        {32'h000E_C000, 1'b1, 1'b0, 2'd1},   // R3 region 12 high
        {32'h000E_FFFF, 1'b0, 1'b0, 2'd1},   // R4 region 12 read
        {32'h000F_0000, 1'b0, 1'b0, 2'd1},   // R3 region 0
        {32'h000F_FFFF, 1'b1, 1'b0, 2'd1},   // R4 region 0 write
        {32'h0009_FFFF, 1'b0, 1'b0, 2'd0},   // R7 below
        {32'h0010_0000, 1'b0, 1'b0, 2'd0},   // R7 above
        {32'h100C_0000, 1'b0, 1'b0, 2'd0},   // R7 upper bits
        {32'h000C_0000, 1'b0, 1'b1, 2'd1}    // R4 smm ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic access(input logic [31:0] a, input logic w, input logic s, output logic [1:0] r);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_smm = s;
        @(negedge clk);
        acc_valid = 1'b0;
        r = route;
    endtask

    initial begin
        logic [31:0] rd;
        logic [1:0]  rt;
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
        ram_mib = 16'd1024; acc_valid = 0; acc_addr = 0; acc_write = 0; acc_smm = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        cfg_read(6'h1C, rd); check("R1 smram reset", rd, 32'h0002_0000);
        cfg_read(6'h16, rd); check("R1 attr reset", rd, 32'h0);
        cfg_read(6'h17, rd); check("R1 attr reset hi", rd, 32'h0);
        @(negedge clk); check("R8 idle none", {30'b0, route}, 32'd0);

        // R10: one write sets 0x59..0x5B together, 0x58 lane ignored
        cfg_write(6'h16, 4'b1111, 32'h0021_30EE);
        cfg_write(6'h17, 4'b1111, 32'h3100_0000);
        cfg_read(6'h16, rd); check("R2 R10 dword 0x58", rd, 32'h0021_3000);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][35:4], VEC[i][3], VEC[i][2], rt);
            check($sformatf("R3/R4/R5/R7 vector %0d", i), {30'b0, rt}, {30'b0, VEC[i][1:0]});
        end

        // R8: no access after one
        @(negedge clk); check("R8 after gap", {30'b0, route}, 32'd0);

        // R2 byte enables
        cfg_write(6'h17, 4'b0001, 32'hFFFF_FFFF);
        cfg_read(6'h17, rd); check("R2 lane enable", rd, 32'h3100_00FF);
        access(32'h000D_4000, 1'b1, 1'b0, rt);   // region 6, byte 0x5C high nibble
        check("R3 region 6 after lane write", {30'b0, rt}, 32'd1);

        // R5 / R6 SMRAM
        cfg_write(6'h1C, 4'b0100, 32'h0040_0000);
        access(32'h000A_8000, 1'b0, 1'b0, rt); check("R5 open", {30'b0, rt}, 32'd1);
        cfg_write(6'h1C, 4'b0100, 32'h0008_0000);
        access(32'h000A_8000, 1'b0, 1'b0, rt); check("R5 enable only non-smm", {30'b0, rt}, 32'd2);
        access(32'h000B_0000, 1'b1, 1'b1, rt); check("R6 smm enabled", {30'b0, rt}, 32'd1);
        cfg_write(6'h1C, 4'b0100, 32'h0000_0000);
        access(32'h000B_0000, 1'b0, 1'b1, rt); check("R6 smm cleared", {30'b0, rt}, 32'd2);
        cfg_write(6'h1C, 4'b0100, 32'h0040_0000);
        access(32'h000B_0000, 1'b0, 1'b1, rt); check("R6 smm follows open", {30'b0, rt}, 32'd1);

        // R9 size byte
        cfg_read(6'h15, rd); check("R9 1024MiB", rd, 32'h8000_0000);
        cfg_write(6'h15, 4'b1000, 32'hAA00_0000);
        cfg_read(6'h15, rd); check("R2 R9 size read-only", rd, 32'h8000_0000);
        ram_mib = 16'd2039; cfg_read(6'h15, rd); check("R9 2039MiB", rd[31:24], 32'd254);
        ram_mib = 16'd2047; cfg_read(6'h15, rd); check("R9 2047MiB", rd[31:24], 32'd255);
        ram_mib = 16'd40000; cfg_read(6'h15, rd); check("R9 saturate", rd[31:24], 32'd255);

        // unimplemented offset
        cfg_write(6'h20, 4'b1111, 32'h1234_5678);
        cfg_read(6'h20, rd); check("R2 unimplemented", rd, 32'h0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule